// File: doc/BRIEF.md
# Processor Activity Watchdog Timer

A synchronous watchdog that monitors a processor's strobe line for signs of life. The processor keeps the watchdog content by toggling the strobe, and either a rising or a falling transition counts. If no transition arrives within a programmable number of timebase ticks, the active-low timeout output falls. That output is meant for a non-maskable interrupt input, or it can be looped back to a manual-reset input to force a system reset.

The timer is held cleared, and does not count, while the system reset is active or while the strobe pin is flagged as undriven. Counting begins once reset is released and the pin is driven to either level. The strobe passes through a synchronizer, and each change of the synchronized level clears the timer. The timeout output also serves as a supply-low indicator: whenever the supply-low flag is high, the output falls at once, without waiting for a clock edge. With the strobe pin left permanently undriven, the output therefore acts purely as a low-line indicator.

Elapsed time comes from a tick-enable input shared with the rest of the supervisory logic, so the period is `TIMEOUT_TICKS` ticks of that timebase.

Top module: `wdt_activity_mon`

## Requirements
- R1: After `rst_ni` is released, with no supply-low, `timeout_no` is high (1).
- R2: With the strobe pin driven, system reset inactive and no strobe transition, `timeout_no` stays high through the first `TIMEOUT_TICKS`-1 tick pulses after the timer was last cleared. It goes low in the clock cycle after the tick pulse that completes `TIMEOUT_TICKS` of them.
- R3: Only cycles with `tick_en_i`=1 advance the timer. Any number of cycles with `tick_en_i`=0 never causes a timeout.
- R4: While `sys_reset_i`=1 the timer stays cleared and tick pulses are ignored. After release, a full `TIMEOUT_TICKS` tick pulses are needed to time out. A single-cycle `sys_reset_i` pulse after a timeout returns `timeout_no` to 1.
- R5: While `strobe_undriven_i`=1 the timer stays cleared and tick pulses are ignored. After the pin is driven again, a full `TIMEOUT_TICKS` tick pulses are needed to time out.
- R6: A rising or a falling transition of `strobe_i` clears the timer within three clock cycles of the change, and this also ends an active timeout. A strobe pulse held for a single clock cycle is captured.
- R7: Once timed out, `timeout_no` stays low through idle cycles and further tick pulses until a strobe transition, a system reset or the undriven condition clears the timer.
- R8: While `supply_low_i`=1, `timeout_no` is 0 combinationally in the same cycle, whether or not the timer has expired. When the flag drops and the timer has not expired, `timeout_no` returns to 1 at once.
- R9: With `strobe_undriven_i` held at 1, `timeout_no` equals the inverse of `supply_low_i` regardless of ticks and strobe activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Timebase tick enable, one cycle per tick |
| strobe_i | input | 1 | Processor activity strobe, asynchronous |
| strobe_undriven_i | input | 1 | Strobe pin is three-stated (synchronous) |
| sys_reset_i | input | 1 | System reset state, active high |
| supply_low_i | input | 1 | Supply below threshold, active high |
| timeout_no | output | 1 | Active-low timeout / low-line output |

## Verification
Two cases are hard to reach from the ports: a strobe pulse lasting a single clock, and a clearing event that lands at every possible point in the countdown. The bench drives ticks one pulse at a time, so the tick count is known exactly. It then sweeps the number of ticks taken before a strobe toggle from zero up to one short of the period, and after each toggle checks the boundary at one tick short of the period and at the full period. A one-cycle strobe pulse is applied while the output is timed out, to show that the narrow pulse clears it and restarts the full period.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Default period: 1 ms ticks -> 1.6 s
  localparam int unsigned WDT_TIMEOUT_TICKS_DEF = 1600;
  localparam int unsigned WDT_SYNC_STAGES_DEF   = 2;

  typedef struct packed {
    logic hold;   // timer forced clear, counting blocked
    logic act;    // strobe activity seen this cycle
  } wdt_ctrl_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[g] <= 1'b0;
          else         chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wdt_edge_det.sv
module wdt_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  // both polarities count as activity
  assign edge_o = level_i ^ prev_q;

  // R6
  edge_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_o |=> (prev_q != $past(prev_q)));
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
  import wdt_pkg::*;
#(
  parameter int unsigned TICKS = WDT_TIMEOUT_TICKS_DEF
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_en_i,
  input  wdt_ctrl_t ctrl_i,
  output logic      expired_o
);
  localparam int unsigned CNT_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;
  logic             clear;

  assign clear = ctrl_i.hold | ctrl_i.act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (clear) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else if (tick_en_i && !expired_q) begin
      if (cnt_q == LAST) expired_q <= 1'b1;
      else               cnt_q     <= cnt_q + 1'b1;
    end
  end

  assign expired_o = expired_q;

  // R4 R5
  hold_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.hold |=> (cnt_q == '0 && !expired_q));

  // R2
  expire_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expired_q) |-> ($past(tick_en_i) && !$past(clear)));

  // R3
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_en_i && !clear) |=> ($stable(cnt_q) && $stable(expired_q)));

  // R7
  expired_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_q && !clear) |=> expired_q);

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/wdt_activity_mon.sv
module wdt_activity_mon
  import wdt_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = WDT_TIMEOUT_TICKS_DEF,
  parameter int unsigned SYNC_STAGES   = WDT_SYNC_STAGES_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_en_i,
  input  logic strobe_i,
  input  logic strobe_undriven_i,
  input  logic sys_reset_i,
  input  logic supply_low_i,
  output logic timeout_no
);
  logic      strobe_sync;
  logic      strobe_edge;
  logic      expired;
  wdt_ctrl_t ctrl;

  wdt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (strobe_i),
    .q_o    (strobe_sync)
  );

  wdt_edge_det u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .level_i (strobe_sync),
    .edge_o  (strobe_edge)
  );

  assign ctrl.hold = sys_reset_i | strobe_undriven_i;
  assign ctrl.act  = strobe_edge;

  wdt_tick_counter #(.TICKS(TIMEOUT_TICKS)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_en_i (tick_en_i),
    .ctrl_i    (ctrl),
    .expired_o (expired)
  );

  // supply-low bypasses the timer, no register on this path
  assign timeout_no = ~(expired | supply_low_i);

  // R8
  supply_low_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    supply_low_i |-> !timeout_no);

  // R9
  lowline_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_undriven_i && $past(strobe_undriven_i)) |-> (timeout_no == !supply_low_i));

  // R6
  act_releases_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_edge && !supply_low_i) |=> (timeout_no || supply_low_i));
endmodule

// File: tb/wdt_activity_mon_tb.sv
module wdt_activity_mon_tb_top;
  localparam int N = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b0;
  logic strobe = 1'b0;
  logic undrv = 1'b0;
  logic sysrst = 1'b0;
  logic slow = 1'b0;
  logic timeout_no;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  wdt_activity_mon #(.TIMEOUT_TICKS(N), .SYNC_STAGES(2)) dut_i (
    .clk_i             (clk_i),
    .rst_ni            (rst_ni),
    .tick_en_i         (tick),
    .strobe_i          (strobe),
    .strobe_undriven_i (undrv),
    .sys_reset_i       (sysrst),
    .supply_low_i      (slow),
    .timeout_no        (timeout_no)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (timeout_no !== exp) begin
      fails++;
      $display("FAIL %s timeout_no actual=%b expected=%b t=%0t", req, timeout_no, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic tick_pulse();
    tick = 1'b1;
    @(negedge clk_i);
    tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) tick_pulse();
  endtask

  task automatic toggle();
    strobe = ~strobe;
    idle(3);
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(3);
    chk("R1", 1'b1);

    idle(40);
    chk("R3", 1'b1);

    for (int k = 1; k <= N + 2; k++) begin
      tick_pulse();
      chk("R2", (k < N) ? 1'b1 : 1'b0);
    end

    idle(20);
    chk("R7", 1'b0);
    ticks(3);
    chk("R7", 1'b0);

    for (int pre = 0; pre < N; pre++) begin
      toggle();
      chk("R6", 1'b1);
      ticks(pre);
      chk("R2", 1'b1);
      toggle();
      ticks(N - 1);
      chk("R6", 1'b1);
      tick_pulse();
      chk("R6", 1'b0);
    end

    // single-cycle strobe pulse while timed out
    strobe = ~strobe;
    @(negedge clk_i);
    strobe = ~strobe;
    idle(4);
    chk("R6", 1'b1);
    ticks(N - 1);
    chk("R6", 1'b1);
    tick_pulse();
    chk("R6", 1'b0);

    // system reset hold
    toggle();
    sysrst = 1'b1;
    ticks(2 * N);
    chk("R4", 1'b1);
    sysrst = 1'b0;
    ticks(N - 1);
    chk("R4", 1'b1);
    tick_pulse();
    chk("R4", 1'b0);
    sysrst = 1'b1;
    @(negedge clk_i);
    sysrst = 1'b0;
    chk("R4", 1'b1);
    ticks(N);
    chk("R2", 1'b0);

    // undriven hold
    undrv = 1'b1;
    @(negedge clk_i);
    chk("R5", 1'b1);
    ticks(2 * N);
    chk("R5", 1'b1);
    undrv = 1'b0;
    ticks(N - 1);
    chk("R5", 1'b1);
    tick_pulse();
    chk("R5", 1'b0);

    // supply low, expired and not expired
    slow = 1'b1;
    #1 chk("R8", 1'b0);
    slow = 1'b0;
    #1 chk("R8", 1'b0);
    @(negedge clk_i);
    toggle();
    chk("R8", 1'b1);
    slow = 1'b1;
    #1 chk("R8", 1'b0);
    slow = 1'b0;
    #1 chk("R8", 1'b1);
    @(negedge clk_i);

    // permanently undriven: low-line only
    undrv = 1'b1;
    for (int i = 0; i < 3 * N; i++) begin
      strobe = (i % 3 == 0) ? ~strobe : strobe;
      tick_pulse();
    end
    chk("R9", 1'b1);
    slow = 1'b1;
    #1 chk("R9", 1'b0);
    @(negedge clk_i);
    ticks(N);
    chk("R9", 1'b0);
    slow = 1'b0;
    #1 chk("R9", 1'b1);
    @(negedge clk_i);
    undrv = 1'b0;
    idle(2);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule